// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block turns one I2C message request into the byte stream an I2C master engine takes from its output FIFO. A request gives a target address (7-bit or 10-bit), a direction flag, a ten-bit flag and a byte count from 1 to 65535. The block cuts the message into chunks of at most 256 bytes.

Each chunk is led by a short tag header: an operation tag and a length byte. The first chunk also carries a start tag and the address bytes. Only the final chunk carries an operation tag that ends the transfer with a stop, so a long transfer runs on the bus with no stop between chunks. For a write, each chunk's payload follows its header and is taken from a valid/ready byte input. For a read, only the headers are produced.

The output is a registered valid/ready byte stream. A request is taken only while the block is idle. When the last byte has been accepted downstream, a one-cycle completion pulse is raised.

Top module: `i2c_tag_streamer`

## Requirements
- R1: A request whose length is 0 is refused: `err` is high for exactly one cycle, the cycle after the request edge, no output byte is produced, and `req_ready` stays high.
- R2: The first chunk begins with the byte 0x81, followed by the address byte {addr[6:0], rd}, where rd is 1 for a read.
- R3: When the ten-bit flag is set, the byte {5'b0, addr[9:7]} is emitted directly after the first address byte. It appears in the first chunk only.
- R4: Every chunk except the last uses operation tag 0x82 for a write or 0x85 for a read.
- R5: The last chunk uses operation tag 0x83 for a write or 0x87 for a read.
- R6: The operation tag is followed by a length byte. This byte holds the chunk size, with 256 encoded as 0x00. A message of L bytes forms ceil(L/256) chunks, and every chunk except the last holds 256 bytes.
- R7: For a write, each chunk's payload bytes follow its length byte, in the order they were taken from the write input. For a read, the write input is never taken from and only tags are emitted.
- R8: While `out_valid` is high and `out_ready` is low, the output byte and `out_valid` hold unchanged into the next cycle.
- R9: `done` is high for one cycle, the cycle after the final byte of the last chunk is accepted. `req_ready` is high again in that same cycle.
- R10: While a message is in progress, `req_ready` is low and requests on the request inputs have no effect on the stream and raise no `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 10 | Target address (7-bit mode uses bits 6:0) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ten | input | 1 | 1 = ten-bit addressing |
| req_len | input | 16 | Message length in bytes |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Payload byte taken this cycle |
| out_data | output | 8 | Tag or payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| done | output | 1 | One-cycle pulse at the end of a message |
| err | output | 1 | One-cycle pulse for a zero-length request |

## Verification
The hardest case to reach from the ports is a chunk boundary under stall. This is the moment the last payload byte of a full 256-byte chunk and the next chunk's operation tag meet a downstream that is refusing bytes, while the write source also has gaps. The stimulus table runs long writes (257, 513 and 600 bytes, one with ten-bit addressing) with out_ready and wr_valid throttled on different periods, so the boundaries fall on stalled and unstalled cycles alike. A 65535-byte read reaches the maximum chunk count, with a final length byte of 0xFF.

// File: rtl/tagstr_pkg.sv
package tagstr_pkg;
  localparam int ADDR_W = 10;

  localparam logic [7:0] TAG_START   = 8'h81;
  localparam logic [7:0] TAG_WR_MORE = 8'h82;
  localparam logic [7:0] TAG_WR_LAST = 8'h83;
  localparam logic [7:0] TAG_RD_MORE = 8'h85;
  localparam logic [7:0] TAG_RD_LAST = 8'h87;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_FIN} run_st_t;
  typedef enum logic [2:0] {H_START, H_ALO, H_AHI, H_OP, H_LEN} hdr_sel_t;
endpackage

// File: rtl/tagstr_chunk.sv
module tagstr_chunk #(
  parameter int LEN_W = 16,
  parameter int CHUNK = 256,
  localparam int CW = $clog2(CHUNK + 1)
) (
  input  logic [LEN_W-1:0] remain,
  output logic [CW-1:0]    chunk_sz,
  output logic             is_last,
  output logic [7:0]       len_code
);
  assign is_last  = (remain <= LEN_W'(CHUNK));
  assign chunk_sz = is_last ? remain[CW-1:0] : CW'(CHUNK);

  generate
    if (CHUNK == 256) begin : g_wrap
      // a full chunk of 256 wraps to 0x00 in the low byte
      assign len_code = chunk_sz[7:0];
    end else begin : g_cmp
      assign len_code = (chunk_sz == CW'(CHUNK)) ? 8'h00 : 8'(chunk_sz);
    end
  endgenerate
endmodule

// File: rtl/tagstr_hdr.sv
module tagstr_hdr
  import tagstr_pkg::*;
(
  input  hdr_sel_t          sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              is_last,
  input  logic [7:0]        len_code,
  output logic [7:0]        hdr_byte
);
  logic [7:0] op_tag;

  always_comb begin
    if (rd) op_tag = is_last ? TAG_RD_LAST : TAG_RD_MORE;
    else    op_tag = is_last ? TAG_WR_LAST : TAG_WR_MORE;
  end

  always_comb begin
    case (sel)
      H_START: hdr_byte = TAG_START;
      H_ALO:   hdr_byte = {addr[6:0], rd};
      H_AHI:   hdr_byte = {5'b0, addr[ADDR_W-1:7]};
      H_OP:    hdr_byte = op_tag;
      H_LEN:   hdr_byte = len_code;
      default: hdr_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_tag_streamer.sv
module i2c_tag_streamer
  import tagstr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CHUNK = 256,
  localparam int CW = $clog2(CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic              req_ten,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              done,
  output logic              err
);
  run_st_t           st_q;
  hdr_sel_t          hs_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, ten_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CW-1:0]     cnt_q;

  logic [CW-1:0] chunk_sz;
  logic          is_last;
  logic [7:0]    len_code, hdr_byte;
  logic          load;

  tagstr_chunk #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_chunk (
    .remain(rem_q), .chunk_sz(chunk_sz), .is_last(is_last), .len_code(len_code)
  );

  tagstr_hdr u_hdr (
    .sel(hs_q), .addr(addr_q), .rd(rd_q), .is_last(is_last),
    .len_code(len_code), .hdr_byte(hdr_byte)
  );

  assign load      = !out_valid || out_ready;
  assign req_ready = (st_q == S_IDLE);
  assign wr_ready  = (st_q == S_PAY) && load;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      hs_q      <= H_START;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      ten_q     <= 1'b0;
      rem_q     <= '0;
      cnt_q     <= '0;
      out_data  <= 8'h00;
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (load) out_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          if (req_len == '0) begin
            err <= 1'b1;
          end else begin
            addr_q <= req_addr;
            rd_q   <= req_rd;
            ten_q  <= req_ten;
            rem_q  <= req_len;
            hs_q   <= H_START;
            st_q   <= S_HDR;
          end
        end
        S_HDR: if (load) begin
          out_data  <= hdr_byte;
          out_valid <= 1'b1;
          case (hs_q)
            H_START: hs_q <= H_ALO;
            H_ALO:   hs_q <= ten_q ? H_AHI : H_OP;
            H_AHI:   hs_q <= H_OP;
            H_OP:    hs_q <= H_LEN;
            default: begin
              if (!rd_q) begin
                st_q  <= S_PAY;
                cnt_q <= chunk_sz;
              end else if (is_last) begin
                st_q <= S_FIN;
              end else begin
                hs_q  <= H_OP;
                rem_q <= rem_q - LEN_W'(chunk_sz);
              end
            end
          endcase
        end
        S_PAY: if (load && wr_valid) begin
          out_data  <= wr_data;
          out_valid <= 1'b1;
          cnt_q     <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            if (is_last) begin
              st_q <= S_FIN;
            end else begin
              st_q  <= S_HDR;
              hs_q  <= H_OP;
              rem_q <= rem_q - LEN_W'(chunk_sz);
            end
          end
        end
        default: if (out_ready) begin
          done <= 1'b1;
          st_q <= S_IDLE;
        end
      endcase
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R1
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid && req_ready && req_len == '0));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready) && req_ready);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);

  // R6
  pay_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_PAY) |-> (cnt_q != '0) && (cnt_q <= CW'(CHUNK)));
endmodule

// File: tb/tb_i2c_tag_streamer.sv
`timescale 1ns/1ps
module tb_i2c_tag_streamer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [9:0]  req_addr = '0;
  logic        req_rd = 1'b0;
  logic        req_ten = 1'b0;
  logic [15:0] req_len = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_tag_streamer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .req_ten(req_ten), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .err(err)
  );

  // {throttle, ten, rd, addr[9:0], len[15:0]}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 10'h050, 16'd1},
    {1'b0, 1'b0, 1'b0, 10'h02A, 16'd256},
    {1'b1, 1'b0, 1'b0, 10'h013, 16'd257},
    {1'b0, 1'b0, 1'b1, 10'h07F, 16'd3},
    {1'b0, 1'b1, 1'b1, 10'h3A5, 16'd512},
    {1'b1, 1'b1, 1'b0, 10'h2C1, 16'd600},
    {1'b0, 1'b0, 1'b1, 10'h011, 16'd65535},
    {1'b1, 1'b0, 1'b0, 10'h001, 16'd513}
  };

  function automatic logic [7:0] pay(input int k);
    return 8'((k * 7) + 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [28:0] v, input bit hold_req);
    logic [7:0] expq[$];
    bit bp = v[28];
    bit ten = v[27];
    bit rd = v[26];
    logic [9:0] addr = v[25:16];
    int len = int'(v[15:0]);
    int nch = (len + 255) / 256;
    int npay = 0;
    int oidx = 0, pidx = 0, cyc = 0, last_acc = -10;
    int bad = 0, first_bad = -1, act_bad = 0, exp_bad = 0;
    int holdbad = 0, donebad = 0, errseen = 0;
    bit got_done = 0, prevstall = 0;
    logic [7:0] prevdata = '0;

    for (int c = 0; c < nch; c++) begin
      int sz = ((len - 256 * c) > 256) ? 256 : (len - 256 * c);
      if (c == 0) begin
        expq.push_back(8'h81);                 // R2
        expq.push_back({addr[6:0], rd});       // R2
        if (ten) expq.push_back({5'b0, addr[9:7]}); // R3
      end
      if (c == nch - 1) expq.push_back(rd ? 8'h87 : 8'h83); // R5
      else              expq.push_back(rd ? 8'h85 : 8'h82); // R4
      expq.push_back((sz == 256) ? 8'h00 : 8'(sz));         // R6
      if (!rd) for (int k = 0; k < sz; k++) begin
        expq.push_back(pay(npay));             // R7
        npay++;
      end
    end

    @(negedge clk);
    req_addr = addr; req_rd = rd; req_ten = ten; req_len = v[15:0];
    req_valid = 1'b1;
    while (!got_done && cyc < 150000) begin
      @(negedge clk);
      if (hold_req) req_len = 16'd0;
      else req_valid = 1'b0;
      out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
      wr_valid  = bp ? ((cyc % 5) != 2) : 1'b1;
      wr_data   = pay(pidx);
      #1;
      if (done) begin
        if (last_acc != cyc - 1 || !req_ready) donebad++;
        got_done = 1;
        req_valid = 1'b0;
      end
      if (err) errseen++;
      if (prevstall && !(out_valid && out_data == prevdata)) holdbad++;
      if (out_valid && out_ready) begin
        if (oidx >= expq.size() || out_data != expq[oidx]) begin
          bad++;
          if (first_bad < 0) begin
            first_bad = oidx;
            act_bad = int'(out_data);
            exp_bad = (oidx < expq.size()) ? int'(expq[oidx]) : -1;
          end
        end
        oidx++;
        if (oidx == expq.size()) last_acc = cyc;
      end
      if (wr_valid && wr_ready) pidx++;
      prevstall = out_valid && !out_ready;
      prevdata = out_data;
      cyc++;
    end
    out_ready = 1'b1; wr_valid = 1'b0; req_valid = 1'b0;

    check(bad == 0, "R2/R3/R4/R5/R6", $sformatf("stream byte %0d len=%0d", first_bad, len),
          act_bad, exp_bad);
    check(oidx == expq.size(), "R6", $sformatf("byte count len=%0d", len), oidx, expq.size());
    check(pidx == npay, "R7", $sformatf("payload taken len=%0d rd=%0d", len, rd), pidx, npay);
    check(holdbad == 0, "R8", "stalled byte changed", holdbad, 0);
    check(got_done && donebad == 0, "R9", "done timing", donebad + (got_done ? 0 : 100), 0);
    check(errseen == 0, "R10", "err while busy", errseen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 R10: idle after reset
    check(req_ready && !out_valid && !done && !err, "R10", "reset state",
          {req_ready, out_valid, done, err}, 4'b1000);

    // R1: zero length refused
    @(negedge clk);
    req_len = 16'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(err == 1'b1, "R1", "err after zero length", err, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); #1;
        if (out_valid || err || !req_ready) seen++;
      end
      check(seen == 0, "R1", "no output after refusal", seen, 0);
    end

    // table of requests
    for (int i = 0; i < NV; i++) run_txn(VEC[i], 1'b0);

    // R10: request held high with zero length during a busy message
    run_txn({1'b1, 1'b0, 1'b0, 10'h044, 16'd300}, 1'b1);
    // R3: ten-bit read crossing one chunk boundary
    run_txn({1'b1, 1'b1, 1'b1, 10'h1FF, 16'd257}, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule